// File: doc/BRIEF.md
# Upset-Masking Scan-Reusing Register

This block is a behavioural model of a WIDTH-bit storage element that survives a single upset. Each bit keeps its system value in a primary copy and a second value in a redundant copy. The redundant copy is the bit's scan cell, used again. A two-input consensus stage (a C-element with a keeper) drives the visible output. When both copies agree, the output takes their common value. When they differ, the output keeps what it held before. A flip in only one copy therefore never reaches the output.

The whole model runs on one clock. The system clock is the `sys_en` strobe and the scan clock is the `scan_shift` strobe, and both are sampled on `clk`. In checking mode a system capture loads both copies on the same edge. In economy mode only the primary copy is loaded and the output follows it directly, so no correction takes place. The redundant copies of all bits form one scan chain from `scan_in` to `scan_out`. The upset inputs let a bench flip any bit of either copy.

Top module: `hr_seu_reg`

## Requirements
- R1: After reset, both copies and the output are all zero, so `q` = 0 and `scan_out` = 0.
- R2: In checking mode (`mode_check` = 1), a cycle with `sys_en` = 1 and `scan_shift` = 0 loads `sys_d` into both copies, and `q` equals `sys_d` after that edge.
- R3: In checking mode, after each edge every output bit equals the common value of its two copies when they agree, and keeps its previous value when they disagree. So two upsets of the same bit in separate cycles make the copies agree again, and `q` takes the new value.
- R4: In checking mode, with no load, a bit flipped in only one copy leaves `q` unchanged. The same bit flipped in both copies in one cycle, starting from agreeing copies, inverts that bit of `q`.
- R5: An upset bit has no effect on a copy that is loaded in the same cycle, whether by a system capture or by a scan shift.
- R6: In economy mode (`mode_check` = 0), `sys_en` loads only the primary copy. The redundant copy keeps its value and `q` equals the primary copy after every edge, so an upset of the primary copy appears on `q`.
- R7: A cycle with `scan_shift` = 1 moves the redundant copies one place toward the MSB: bit 0 takes `scan_in`, and `scan_out` is the MSB of the redundant copy. A shift takes priority over a system capture for the redundant copy, while the primary copy still captures `sys_d`.
- R8: A scan shift with no system capture and no primary upset leaves `q` unchanged whenever `q` equalled the primary copy before the shift.
- R9: After a checking-mode capture of a word, WIDTH shifts present that word on `scan_out`, MSB first, one bit per shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which all strobes are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_check | input | 1 | 1 = checking mode, 0 = economy mode |
| sys_en | input | 1 | System capture strobe |
| sys_d | input | WIDTH | System data |
| scan_shift | input | 1 | Scan clock strobe, shifts the redundant chain |
| scan_in | input | 1 | Serial scan input into bit 0 |
| scan_out | output | 1 | Serial scan output, MSB of the redundant copy |
| upset_pri | input | WIDTH | Per-bit flip of the primary copy |
| upset_red | input | WIDTH | Per-bit flip of the redundant copy |
| q | output | WIDTH | Hardened output from the consensus stage |

## Verification
Two pairs of functions can meet in one cycle. The first is a load and an upset of the same copy. The second is a scan shift and a system capture. The directed part puts all-ones upset masks on both copies in the same cycle as a capture, and it raises `scan_shift` together with `sys_en`. The random part draws each of these strobes on its own, so they overlap often. Every cycle is judged against a reference model built from the load-wins and shift-wins rules. That model also tracks when the two copies disagree after a shift, so that a shift which disturbs the output is caught.

// File: rtl/hr_seu_pkg.sv
package hr_seu_pkg;
    typedef enum logic {
        MODE_ECON  = 1'b0,
        MODE_CHECK = 1'b1
    } hr_mode_e;
endpackage

// File: rtl/hr_copy_next.sv
// Next value of one storage copy: a load wins over an upset in the same cycle.
module hr_copy_next #(
    parameter int WIDTH = 8
) (
    input  logic             load,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] flip,
    output logic [WIDTH-1:0] nxt
);
    always_comb begin
        nxt = load ? data : (cur ^ flip);
    end
endmodule

// File: rtl/hr_scan_step.sv
// One shift of the redundant chain toward the MSB.
module hr_scan_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_in,
    output logic [WIDTH-1:0] shifted
);
    generate
        if (WIDTH == 1) begin : g_single
            assign shifted = ser_in;
        end else begin : g_multi
            assign shifted = {cur[WIDTH-2:0], ser_in};
        end
    endgenerate
endmodule

// File: rtl/hr_celem.sv
// Per-bit consensus: an agreeing pair drives the bit, a split pair keeps it.
module hr_celem #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] y
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign y[i] = (in_a[i] == in_b[i]) ? in_a[i] : held[i];
        end
    endgenerate
endmodule

// File: rtl/hr_seu_reg.sv
module hr_seu_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_check,
    input  logic             sys_en,
    input  logic [WIDTH-1:0] sys_d,
    input  logic             scan_shift,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [WIDTH-1:0] upset_pri,
    input  logic [WIDTH-1:0] upset_red,
    output logic [WIDTH-1:0] q
);
    import hr_seu_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] pri;
        logic [WIDTH-1:0] red;
        logic [WIDTH-1:0] hold;
    } state_t;

    state_t st_d, st_q;

    logic             check_on;
    logic             red_load;
    logic [WIDTH-1:0] red_src;
    logic [WIDTH-1:0] chain_nx;
    logic [WIDTH-1:0] pri_nx;
    logic [WIDTH-1:0] red_nx;
    logic [WIDTH-1:0] cel_y;
    logic [WIDTH-1:0] pri_q;
    logic [WIDTH-1:0] red_q;

    assign check_on = (hr_mode_e'(mode_check) == MODE_CHECK);
    assign red_load = scan_shift | (sys_en & check_on);
    assign red_src  = scan_shift ? chain_nx : sys_d;

    hr_scan_step #(.WIDTH(WIDTH)) u_chain (
        .cur     (st_q.red),
        .ser_in  (scan_in),
        .shifted (chain_nx)
    );

    hr_copy_next #(.WIDTH(WIDTH)) u_pri (
        .load (sys_en),
        .data (sys_d),
        .cur  (st_q.pri),
        .flip (upset_pri),
        .nxt  (pri_nx)
    );

    hr_copy_next #(.WIDTH(WIDTH)) u_red (
        .load (red_load),
        .data (red_src),
        .cur  (st_q.red),
        .flip (upset_red),
        .nxt  (red_nx)
    );

    hr_celem #(.WIDTH(WIDTH)) u_cel (
        .in_a (pri_nx),
        .in_b (red_nx),
        .held (st_q.hold),
        .y    (cel_y)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pri  = pri_nx;
        st_d.red  = red_nx;
        st_d.hold = check_on ? cel_y : pri_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pri_q    = st_q.pri;
    assign red_q    = st_q.red;
    assign q        = st_q.hold;
    assign scan_out = st_q.red[MSB];
endmodule

// File: rtl/hr_seu_reg_chk.sv
module hr_seu_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_check,
    input logic             sys_en,
    input logic [WIDTH-1:0] sys_d,
    input logic             scan_shift,
    input logic             scan_in,
    input logic [WIDTH-1:0] upset_pri,
    input logic [WIDTH-1:0] upset_red,
    input logic [WIDTH-1:0] pri_q,
    input logic [WIDTH-1:0] red_q,
    input logic [WIDTH-1:0] q
);
    // R3: agreeing copies drive the output
    a_r3_agree_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_q == red_q) |-> (q == pri_q));

    // R4: a flip in a single copy is masked
    a_r4_single_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_check && !sys_en && !scan_shift && pri_q == red_q && q == pri_q
         && (upset_pri & upset_red) == '0) |=> $stable(q));

    // R5 and R2: a checking-mode capture loads both copies despite upsets
    a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && mode_check && !scan_shift) |=>
        (pri_q == $past(sys_d) && red_q == $past(sys_d) && q == $past(sys_d)));

    // R6: economy mode output follows the primary copy
    a_r6_econ_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_check |=> (q == pri_q));

    // R7: shift enters scan_in at bit 0
    a_r7_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        scan_shift |=> (red_q[0] == $past(scan_in)));

    // R8: a scan shift leaves a settled output alone
    a_r8_shift_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_shift && !sys_en && upset_pri == '0 && q == pri_q) |=> $stable(q));
endmodule

bind hr_seu_reg hr_seu_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_check (mode_check),
    .sys_en     (sys_en),
    .sys_d      (sys_d),
    .scan_shift (scan_shift),
    .scan_in    (scan_in),
    .upset_pri  (upset_pri),
    .upset_red  (upset_red),
    .pri_q      (pri_q),
    .red_q      (red_q),
    .q          (q)
);

// File: tb/hr_seu_reg_tb.sv
module hr_seu_reg_tb;
    localparam int W        = 8;
    localparam int CLK_PER  = 10;
    localparam int RND_STEP = 4000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_check = 1'b1;
    logic         sys_en = 1'b0;
    logic [W-1:0] sys_d = '0;
    logic         scan_shift = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic [W-1:0] upset_pri = '0;
    logic [W-1:0] upset_red = '0;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [W-1:0] m_pri = '0, m_red = '0, m_out = '0;

    always #(CLK_PER/2) clk = ~clk;

    hr_seu_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_check(mode_check), .sys_en(sys_en),
        .sys_d(sys_d), .scan_shift(scan_shift), .scan_in(scan_in),
        .scan_out(scan_out), .upset_pri(upset_pri), .upset_red(upset_red), .q(q)
    );

    function automatic logic [W-1:0] consensus(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic [W-1:0] prev);
        logic [W-1:0] agree;
        agree = ~(a ^ b);
        return (a & agree) | (prev & ~agree);
    endfunction

    task automatic model_edge();
        logic [W-1:0] np, nr;
        np = sys_en ? sys_d : (m_pri ^ upset_pri);
        if (scan_shift)               nr = {m_red[W-2:0], scan_in};
        else if (sys_en && mode_check) nr = sys_d;
        else                           nr = m_red ^ upset_red;
        m_out = mode_check ? consensus(np, nr, m_out) : np;
        m_pri = np;
        m_red = nr;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (q !== m_out) begin
            errors++;
            $display("FAIL %s q actual=%h expected=%h", tag, q, m_out);
        end
        checks++;
        if (scan_out !== m_red[W-1]) begin
            errors++;
            $display("FAIL %s scan_out actual=%b expected=%b", tag, scan_out, m_red[W-1]);
        end
    endtask

    task automatic step(input string tag, input logic mc, input logic en,
                        input logic [W-1:0] d, input logic sh, input logic si,
                        input logic [W-1:0] up, input logic [W-1:0] ur);
        mode_check = mc; sys_en = en; sys_d = d; scan_shift = sh;
        scan_in = si; upset_pri = up; upset_red = ur;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PER * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        step("R2 capture", 1, 1, 8'hA5, 0, 0, '0, '0);
        step("R4 primary flip masked", 1, 0, '0, 0, 0, 8'h01, '0);
        step("R5 capture beats upsets", 1, 1, 8'h3C, 0, 0, 8'hFF, 8'hFF);
        step("R4 redundant flip masked", 1, 0, '0, 0, 0, '0, 8'h80);
        step("R3 copies agree again", 1, 0, '0, 0, 0, 8'h80, '0);
        step("R4 double flip shows", 1, 0, '0, 0, 0, 8'h02, 8'h02);
        step("R6 economy flip shows", 0, 0, '0, 0, 0, 8'h01, '0);
        step("R6 economy capture", 0, 1, 8'h55, 0, 0, '0, '0);
        step("R3 split copies hold", 1, 0, '0, 0, 0, '0, '0);
        step("R2 capture for scan", 1, 1, 8'hC3, 0, 0, '0, '0);
        for (int i = 0; i < W; i++) begin
            step("R9 scan readout R8 quiet", 1, 0, '0, 1, 1'b0, '0, 8'hFF);
        end
        step("R7 shift with capture", 1, 1, 8'h96, 1, 1'b1, '0, '0);
        step("R7 shift in", 1, 0, '0, 1, 1'b1, '0, '0);

        for (int i = 0; i < RND_STEP; i++) begin
            word = W'($urandom);
            step("RND R3 R4 R5 R7",
                 ($urandom % 8) != 0,
                 ($urandom % 4) == 0,
                 word,
                 ($urandom % 5) == 0,
                 1'($urandom),
                 (($urandom % 6) == 0) ? W'(1 << ($urandom % W)) : '0,
                 (($urandom % 6) == 0) ? W'(1 << ($urandom % W)) : '0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule